// File: doc/BRIEF.md
# Virtual Interface Transmit Command Sequencer

Software on several processors writes transmit commands into a register window that repeats once per virtual interface. The page of the write address selects the interface, so each processor can post its own commands without taking a lock. The sequencer keeps every accepted command in one queue, in arrival order. It hands the commands one at a time to a single transmit engine over a valid/ready handshake.

A command carries a byte count and a flag that marks the final fragment of a packet. When an issued command is not the final fragment, the sequencer binds itself to that interface. Commands from other interfaces wait in the queue, keeping their order, until the same interface supplies and issues its final fragment. The sequencer then takes the oldest queued command again, whatever interface it comes from. A status word per interface, picked by a select input, shows whether the interface has work outstanding, whether its last packet went out, and how many bytes that packet carried.

Top module: `vif_tx_sequencer`

## Requirements
- R1: When `cfg_virt_en` (configuration bit 5) is 1, the interface index of a write is `(wr_addr >> 8) & 0xff`. When it is 0, every write goes to interface 0.
- R2: A write whose decoded index is NUM_VIF or higher is refused: `wr_refused` is 1 in the same cycle and nothing is queued.
- R3: While no packet is open, commands are issued strictly in the order they were accepted, across all interfaces.
- R4: Issuing a command with `cmd_last`=0 opens a packet on that interface. Until that interface's command with `cmd_last`=1 is issued, `cmd_valid` is asserted only for commands from that interface, and it stays low when none is queued.
- R5: Commands from other interfaces that are accepted while a packet is open stay queued without loss and keep their relative order. They are issued in that order once the packet closes.
- R6: While `cfg_tx_en` (configuration bit 1) is 0, `cmd_valid` is 0 and queued commands are kept.
- R7: When the queue holds DEPTH commands, a further write is refused (`wr_refused`=1) and is never issued.
- R8: Status bit 31 (busy) is 1 while the interface has a queued command or an open packet.
- R9: Status bit 30 (complete) is set when a command of that interface with `cmd_last`=1 is issued. It is cleared when a new command of that interface is accepted.
- R10: Status bits 19:0 hold the sum of the lengths of the fragments issued so far in the interface's current or most recent packet. All other status bits are 0.
- R11: After reset `cmd_valid` and `wr_refused` are 0 and every status word is 0.
- R12: While `cmd_valid` is 1 and `cmd_ready` is 0, the next cycle either keeps `cmd_valid` with unchanged `cmd_vif`, `cmd_len` and `cmd_last`, or has `cfg_tx_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tx_en | input | 1 | Transmit enable (configuration bit 1) |
| cfg_virt_en | input | 1 | Virtual addressing enable (configuration bit 5) |
| wr_en | input | 1 | Command write strobe |
| wr_addr | input | ADDR_W | Write address; bits 15:8 select the interface |
| wr_len | input | 20 | Fragment length in bytes |
| wr_last | input | 1 | Fragment ends its packet |
| wr_refused | output | 1 | Write in this cycle was not accepted |
| cmd_valid | output | 1 | A command is offered to the engine |
| cmd_ready | input | 1 | Engine takes the offered command |
| cmd_vif | output | 8 | Interface of the offered command |
| cmd_len | output | 20 | Length of the offered command |
| cmd_last | output | 1 | Offered command ends its packet |
| stat_sel | input | $clog2(NUM_VIF) | Interface whose status is shown |
| stat_word | output | 32 | Status word of the selected interface |

## Verification
The bench builds the sequencer with NUM_VIF=4 and DEPTH=4. With only four interfaces, every one of the 256 address pages can be written in both addressing modes, and each page either issues on the right interface or is refused. A queue of four entries fills within a few writes, so the refusal at the limit and the recovery after draining are reached directly. Packets of up to three fragments, interleaved with other interfaces, exercise the bound state, the queue skipping over waiting commands, and the summed status length.

// File: rtl/vtxs_pkg.sv
package vtxs_pkg;
  localparam int VIDX_W = 8;   // width of the interface field in the address
  localparam int VSHIFT = 8;   // position of the interface field
  localparam int LEN_W  = 20;  // fragment length width
  localparam int ST_W   = 32;
  localparam int ST_BUSY = 31;
  localparam int ST_DONE = 30;

  typedef struct packed {
    logic [VIDX_W-1:0] vif;
    logic [LEN_W-1:0]  len;
    logic              last;
  } txcmd_t;

  // interface index of a write page; mode off folds everything onto 0
  function automatic logic [VIDX_W-1:0] f_vif_index(input logic [VIDX_W-1:0] page,
                                                    input logic virt_en);
    return virt_en ? (page & 8'hff) : '0;
  endfunction

  // running byte count of a packet: restart on a first fragment
  function automatic logic [LEN_W-1:0] f_copy_len(input logic cont,
                                                  input logic [LEN_W-1:0] old,
                                                  input logic [LEN_W-1:0] add);
    return cont ? old + add : add;
  endfunction

  function automatic logic [ST_W-1:0] f_status(input logic busy, input logic done,
                                               input logic [LEN_W-1:0] len);
    logic [ST_W-1:0] w;
    w = '0;
    w[ST_BUSY] = busy;
    w[ST_DONE] = done;
    w[LEN_W-1:0] = len;
    return w;
  endfunction
endpackage

// File: rtl/vtxs_addr_decode.sv
module vtxs_addr_decode
  import vtxs_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_VIF = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              virt_en,
  output logic [VIDX_W-1:0] vif,
  output logic              vif_ok
);
  localparam logic [VIDX_W:0] VIF_LIM = (VIDX_W+1)'(NUM_VIF);

  logic unused_offset;
  assign unused_offset = ^addr[VSHIFT-1:0];

  generate
    if (ADDR_W > VSHIFT + VIDX_W) begin : g_high
      logic unused_high;
      assign unused_high = ^addr[ADDR_W-1:VSHIFT+VIDX_W];
    end
  endgenerate

  assign vif    = f_vif_index(addr[VSHIFT +: VIDX_W], virt_en);
  assign vif_ok = ({1'b0, vif} < VIF_LIM);
endmodule

// File: rtl/vtxs_cmd_queue.sv
module vtxs_cmd_queue
  import vtxs_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  txcmd_t            push_cmd,
  input  logic              pop,
  input  logic              match_en,
  input  logic [VIDX_W-1:0] match_vif,
  output logic              full,
  output logic              sel_found,
  output txcmd_t            sel_cmd
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  txcmd_t           q  [DEPTH];
  txcmd_t           nq [DEPTH];
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cnt_after_pop;
  logic [IDX_W-1:0] sel_idx;

  assign full = (count == CNT_W'(DEPTH));

  // oldest live entry, restricted to one interface when match_en is set
  always_comb begin
    sel_found = 1'b0;
    sel_idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!sel_found && (CNT_W'(i) < count) && (!match_en || q[i].vif == match_vif)) begin
        sel_found = 1'b1;
        sel_idx   = IDX_W'(i);
      end
    end
  end
  assign sel_cmd = q[sel_idx];

  // remove the issued entry by closing the gap, then append at the tail
  always_comb begin
    for (int i = 0; i < DEPTH; i++) nq[i] = q[i];
    cnt_after_pop = count;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= sel_idx) nq[i] = q[i + 1];
      end
      nq[DEPTH-1]   = '0;
      cnt_after_pop = count - 1'b1;
    end
    if (push) nq[cnt_after_pop[IDX_W-1:0]] = push_cmd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else begin
      count <= cnt_after_pop + CNT_W'(push);
      for (int i = 0; i < DEPTH; i++) q[i] <= nq[i];
    end
  end
endmodule

// File: rtl/vtxs_status_table.sv
module vtxs_status_table
  import vtxs_pkg::*;
#(
  parameter int NUM_VIF = 16,
  parameter int DEPTH   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc,
  input  logic [VIDX_W-1:0]          acc_vif,
  input  logic                       fire,
  input  txcmd_t                     fire_cmd,
  input  logic                       cont,
  input  logic                       lock_active,
  input  logic [VIDX_W-1:0]          lock_vif,
  input  logic [$clog2(NUM_VIF)-1:0] sel,
  output logic [ST_W-1:0]            stat_word,
  output logic [NUM_VIF-1:0]         done_vec
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [NUM_VIF-1:0] busy_vec;
  logic [LEN_W-1:0]   len_arr [NUM_VIF];

  genvar v;
  generate
    for (v = 0; v < NUM_VIF; v++) begin : g_vif
      logic             hit_acc;
      logic             hit_fire;
      logic [CNT_W-1:0] pend_q;
      logic             done_q;
      logic [LEN_W-1:0] len_q;

      assign hit_acc  = acc && (acc_vif == VIDX_W'(v));
      assign hit_fire = fire && (fire_cmd.vif == VIDX_W'(v));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend_q <= '0;
          done_q <= 1'b0;
          len_q  <= '0;
        end else begin
          pend_q <= pend_q + CNT_W'(hit_acc) - CNT_W'(hit_fire);
          if (hit_acc)                      done_q <= 1'b0;
          else if (hit_fire && fire_cmd.last) done_q <= 1'b1;
          if (hit_fire) len_q <= f_copy_len(cont, len_q, fire_cmd.len);
        end
      end

      assign busy_vec[v] = (pend_q != '0) || (lock_active && lock_vif == VIDX_W'(v));
      assign done_vec[v] = done_q;
      assign len_arr[v]  = len_q;
    end
  endgenerate

  assign stat_word = f_status(busy_vec[sel], done_vec[sel], len_arr[sel]);
endmodule

// File: rtl/vif_tx_sequencer.sv
module vif_tx_sequencer
  import vtxs_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_VIF = 16,
  parameter int DEPTH   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_tx_en,
  input  logic                       cfg_virt_en,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [19:0]                wr_len,
  input  logic                       wr_last,
  output logic                       wr_refused,
  output logic                       cmd_valid,
  input  logic                       cmd_ready,
  output logic [7:0]                 cmd_vif,
  output logic [19:0]                cmd_len,
  output logic                       cmd_last,
  input  logic [$clog2(NUM_VIF)-1:0] stat_sel,
  output logic [31:0]                stat_word
);
  // named internal events, observed by the bound checker
  logic [VIDX_W-1:0]  w_vif;
  logic               w_vif_ok;
  logic               q_full;
  logic               sel_found;
  txcmd_t             sel_cmd;
  txcmd_t             push_cmd;
  logic               push;
  logic               fire;
  logic               locked;
  logic [VIDX_W-1:0]  lock_vif;
  logic               cont;
  logic [NUM_VIF-1:0] done_vec;

  vtxs_addr_decode #(.ADDR_W(ADDR_W), .NUM_VIF(NUM_VIF)) dec_i (
    .addr(wr_addr), .virt_en(cfg_virt_en), .vif(w_vif), .vif_ok(w_vif_ok)
  );

  assign push       = wr_en && w_vif_ok && !q_full;
  assign wr_refused = wr_en && !push;
  assign push_cmd   = '{vif: w_vif, len: wr_len, last: wr_last};

  vtxs_cmd_queue #(.DEPTH(DEPTH)) q_i (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_cmd(push_cmd), .pop(fire),
    .match_en(locked), .match_vif(lock_vif),
    .full(q_full), .sel_found(sel_found), .sel_cmd(sel_cmd)
  );

  assign cmd_valid = cfg_tx_en && sel_found;
  assign fire      = cmd_valid && cmd_ready;
  assign cmd_vif   = sel_cmd.vif;
  assign cmd_len   = sel_cmd.len;
  assign cmd_last  = sel_cmd.last;
  assign cont      = locked && (lock_vif == sel_cmd.vif);

  // binding to an interface with an open packet
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      lock_vif <= '0;
    end else if (fire) begin
      locked   <= !sel_cmd.last;
      lock_vif <= sel_cmd.vif;
    end
  end

  vtxs_status_table #(.NUM_VIF(NUM_VIF), .DEPTH(DEPTH)) st_i (
    .clk(clk), .rst_n(rst_n),
    .acc(push), .acc_vif(w_vif),
    .fire(fire), .fire_cmd(sel_cmd), .cont(cont),
    .lock_active(locked), .lock_vif(lock_vif),
    .sel(stat_sel), .stat_word(stat_word), .done_vec(done_vec)
  );
endmodule

// File: rtl/vtxs_checker.sv
module vtxs_checker #(
  parameter int NUM_VIF = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_tx_en,
  input logic               push,
  input logic [7:0]         w_vif,
  input logic               q_full,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [7:0]         cmd_vif,
  input logic [19:0]        cmd_len,
  input logic               cmd_last,
  input logic               locked,
  input logic [7:0]         lock_vif,
  input logic [NUM_VIF-1:0] done_vec
);
  localparam int SEL_W = $clog2(NUM_VIF);

  logic fire;
  assign fire = cmd_valid && cmd_ready;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !push); // R7

  AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_tx_en |-> !cmd_valid); // R6

  AST_LOCK_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cmd_last) |=> (locked && lock_vif == $past(cmd_vif))); // R4

  AST_LOCK_ONLY_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && cmd_valid) |-> (cmd_vif == lock_vif)); // R4

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (!cfg_tx_en ||
      (cmd_valid && $stable(cmd_vif) && $stable(cmd_len) && $stable(cmd_last)))); // R12

  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_last && !(push && w_vif == cmd_vif))
      |=> done_vec[$past(cmd_vif[SEL_W-1:0])]); // R9
endmodule

bind vif_tx_sequencer vtxs_checker #(.NUM_VIF(NUM_VIF)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .push(push), .w_vif(w_vif),
  .q_full(q_full), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_vif(cmd_vif),
  .cmd_len(cmd_len), .cmd_last(cmd_last), .locked(locked), .lock_vif(lock_vif),
  .done_vec(done_vec)
);

// File: tb/vif_tx_sequencer_tb_top.sv
module vif_tx_sequencer_tb_top;
  localparam int NV = 4;
  localparam int DP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_tx_en = 1'b0;
  logic        cfg_virt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [19:0] wr_len = '0;
  logic        wr_last = 1'b0;
  logic        wr_refused;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [7:0]  cmd_vif;
  logic [19:0] cmd_len;
  logic        cmd_last;
  logic [1:0]  stat_sel = '0;
  logic [31:0] stat_word;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vif_tx_sequencer #(.ADDR_W(16), .NUM_VIF(NV), .DEPTH(DP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .cfg_virt_en(cfg_virt_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_len(wr_len), .wr_last(wr_last),
    .wr_refused(wr_refused), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_vif(cmd_vif), .cmd_len(cmd_len), .cmd_last(cmd_last),
    .stat_sel(stat_sel), .stat_word(stat_word)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // status word as the requirements define it
  function automatic logic [31:0] st(input bit busy, input bit cmpl, input int len);
    return {busy, cmpl, 10'b0, len[19:0]};
  endfunction

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [15:0] a, input int len, input bit last,
                    input bit exp_ref, input string req);
    wr_en = 1'b1; wr_addr = a; wr_len = len[19:0]; wr_last = last;
    #2 chk({31'b0, wr_refused}, {31'b0, exp_ref}, req);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic issue(input int v, input int len, input bit last, input string req);
    chk({31'b0, cmd_valid}, 32'd1, req);
    chk({24'b0, cmd_vif}, v, req);
    chk({12'b0, cmd_len}, len, req);
    chk({31'b0, cmd_last}, {31'b0, last}, req);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
  endtask

  task automatic stat(input int v, input logic [31:0] exp, input string req);
    stat_sel = v[1:0];
    #1 chk(stat_word, exp, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk({31'b0, cmd_valid}, 0, "R11 valid in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk({31'b0, cmd_valid}, 0, "R11 valid after reset");
    chk({31'b0, wr_refused}, 0, "R11 refused after reset");
    for (int v = 0; v < NV; v++) stat(v, 0, "R11 status");

    cfg_tx_en = 1'b1; cfg_virt_en = 1'b1;

    // R4/R5/R8/R10: open packet on vif0, others wait
    wr(16'h0000, 5, 0, 0, "R1 accept vif0");
    issue(0, 5, 0, "R4 first fragment");
    stat(0, st(1, 0, 5), "R8 busy while open");
    wr(16'h0200, 7, 1, 0, "R5 accept vif2");
    wr(16'h0300, 8, 1, 0, "R5 accept vif3");
    chk({31'b0, cmd_valid}, 0, "R4 others held");
    stat(2, st(1, 0, 0), "R8 busy when queued");
    wr(16'h0000, 6, 1, 0, "R4 accept rest");
    issue(0, 6, 1, "R4 owner next");
    stat(0, st(0, 1, 11), "R10 summed length");
    issue(2, 7, 1, "R5 order kept");
    issue(3, 8, 1, "R5 order kept");
    stat(2, st(0, 1, 7), "R9 complete");
    chk({31'b0, cmd_valid}, 0, "R5 drained");

    // R4/R5: three fragments with another interface in between
    wr(16'h0100, 100, 0, 0, "R4 accept f1");
    wr(16'h0200, 9, 1, 0, "R5 accept other");
    wr(16'h0100, 200, 0, 0, "R4 accept f2");
    wr(16'h0100, 300, 1, 0, "R4 accept f3");
    issue(1, 100, 0, "R4 f1");
    issue(1, 200, 0, "R4 skip to owner f2");
    stat(1, st(1, 0, 300), "R10 partial sum");
    issue(1, 300, 1, "R4 owner f3");
    stat(1, st(0, 1, 600), "R10 three fragment sum");
    issue(2, 9, 1, "R5 waiting issued");

    // R3/R12: arrival order and held offer
    wr(16'h0300, 31, 1, 0, "R3 w3");
    wr(16'h0100, 11, 1, 0, "R3 w1");
    wr(16'h0000, 1, 1, 0, "R3 w0");
    wr(16'h0200, 21, 1, 0, "R3 w2");
    repeat (3) @(negedge clk);
    chk({24'b0, cmd_vif}, 3, "R12 offer held");
    chk({12'b0, cmd_len}, 31, "R12 offer held");
    stat(1, st(1, 0, 600), "R9 cleared on accept");
    issue(3, 31, 1, "R3 order");
    issue(1, 11, 1, "R3 order");
    issue(0, 1, 1, "R3 order");
    issue(2, 21, 1, "R3 order");
    stat(1, st(0, 1, 11), "R10 new packet restarts");

    // R6: transmit disabled
    cfg_tx_en = 1'b0;
    wr(16'h0100, 4, 1, 0, "R6 accept");
    wr(16'h0200, 5, 1, 0, "R6 accept");
    repeat (3) @(negedge clk);
    chk({31'b0, cmd_valid}, 0, "R6 no issue when off");
    cfg_tx_en = 1'b1;
    #1;
    issue(1, 4, 1, "R6 kept");
    issue(2, 5, 1, "R6 kept");

    // R7: full queue
    cfg_tx_en = 1'b0;
    for (int v = 0; v < DP; v++) wr(16'(v << 8), 40 + v, 1, 0, "R7 fill");
    wr(16'h0100, 99, 1, 1, "R7 refused when full");
    cfg_tx_en = 1'b1;
    #1;
    for (int v = 0; v < DP; v++) issue(v, 40 + v, 1, "R7 drain");
    chk({31'b0, cmd_valid}, 0, "R7 refused not queued");

    // R1/R2: every page with addressing on
    for (int p = 0; p < 256; p++) begin
      wr(16'(p << 8), p, 1, (p >= NV), "R2 page decode");
      if (p < NV) issue(p, p, 1, "R1 page to interface");
    end
    chk({31'b0, cmd_valid}, 0, "R2 refused pages not queued");

    // R1: every page with addressing off maps to interface 0
    cfg_virt_en = 1'b0;
    for (int p = 0; p < 256; p++) begin
      wr(16'((p << 8) | 8'h5a), p + 1, 1, 0, "R1 mode off accept");
      issue(0, p + 1, 1, "R1 mode off to vif0");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule